// File: doc/BRIEF.md
# Floating-Point Exception Flag and Serialize Controller

This block sits next to a pipelined floating-point unit. It keeps five sticky exception flags and a summary bit, and it controls when the dispatch stage may issue floating-point work. In fast mode an exception never interrupts the processor. The completing operation only sets its flags, and software tests the summary when it chooses to, for example at the end of a statement, a routine or the whole program. In serialize mode the block lets only one floating-point operation be in flight at a time. An exception at completion then raises a level interrupt and captures the address of the failing instruction. This makes the fault precise, at the cost of throughput.

Dispatch is a valid/ready stream. The dispatch stage raises `issue_valid`, and an operation enters the unit on a cycle where `issue_valid` and `issue_ready` are both high. The dispatch stage must keep the operation pending while `issue_ready` is low. Completions cannot be stalled, so they carry no ready signal. A completion reports its exception bits and the instruction address on the cycle where `done_valid` is high. Software reaches the flags through a single-cycle access port. `sw_rdata` always shows the flag value as it stands before the access takes effect.

Top module: `fpx_guard`

## Requirements
- R1: A completion with `done_valid` high sets, on the next clock edge, every flag whose bit is high in `done_exc`. The bit order is 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact. Flags stay set until software changes them.
- R2: `flag_summary` is high exactly when at least one flag is set, so it goes low only once every flag has been cleared.
- R3: `sw_op` selects the software access: 0 reads with no change, 1 sets the flags given in `sw_wdata`, 2 clears the flags given in `sw_wdata`, 3 swaps (the flags take `sw_wdata`). In every case `sw_rdata` returns the value held before the access.
- R4: When a software clear or swap and a hardware exception touch the same flag in the same cycle, the flag ends up set.
- R5: In fast mode (`ser_mode` low) `trap_irq` never rises, and several operations may be in flight at once.
- R6: In serialize mode `issue_ready` is low while an operation is in flight or while `trap_irq` is high, so at most one operation is ever in flight.
- R7: In serialize mode a completion with any `done_exc` bit set raises `trap_irq` on the next edge and loads `fault_addr` with that completion's `done_addr`.
- R8: `trap_irq` stays high until `trap_ack` is seen and falls on the edge after it.
- R9: A change of `ser_mode_req` takes effect in `ser_mode` only on an edge where nothing is in flight. `issue_ready` stays low while the requested and current modes differ.
- R10: In fast mode `issue_ready` goes low once MAX_INFLIGHT operations are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode_req | input | 1 | Requested mode: 1 for serialize, 0 for fast |
| ser_mode | output | 1 | Mode currently in force |
| issue_valid | input | 1 | Dispatch stage has a floating-point operation ready to issue |
| issue_ready | output | 1 | Dispatch gate open; the operation issues when valid and ready are both high |
| done_valid | input | 1 | An operation completes this cycle |
| done_exc | input | 5 | Exception bits of the completing operation |
| done_addr | input | ADDR_W | Instruction address of the completing operation |
| sw_op | input | 2 | Software access code |
| sw_wdata | input | 5 | Software write mask or value |
| sw_rdata | output | 5 | Flags before this cycle's access |
| flag_summary | output | 1 | OR of all sticky flags |
| trap_irq | output | 1 | Precise exception interrupt (level) |
| trap_ack | input | 1 | Software acknowledge of the interrupt |
| fault_addr | output | ADDR_W | Address of the instruction that raised the interrupt |

## Verification
A table of software accesses runs with and without concurrent hardware exceptions. It tells set, clear and swap apart, confirms that the returned value is always the one from before the access, and shows that a hardware set survives a same-cycle clear or swap. Back-to-back issues in fast mode show that dispatch is not limited, that the in-flight cap holds, and that exceptions only set flags. A pending mode change during an in-flight operation shows that the switch waits for the unit to drain. A serialize-mode sequence with a clean completion and then a faulting one tells the single-issue gate apart from the interrupt hold, and checks the captured address and the acknowledge.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_EXC = 5;
  typedef logic [NUM_EXC-1:0] exc_vec_t;
  typedef enum logic [1:0] {
    SW_READ  = 2'd0,
    SW_SET   = 2'd1,
    SW_CLEAR = 2'd2,
    SW_SWAP  = 2'd3
  } sw_op_e;
endpackage

// File: rtl/fpx_flags.sv
module fpx_flags
  import fpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  exc_vec_t hw_set,
  input  sw_op_e   op,
  input  exc_vec_t wdata,
  output exc_vec_t flags,
  output logic     summary
);
  exc_vec_t sw_val;

  always_comb begin
    case (op)
      SW_SET:   sw_val = flags | wdata;
      SW_CLEAR: sw_val = flags & ~wdata;
      SW_SWAP:  sw_val = wdata;
      default:  sw_val = flags;
    endcase
  end

  // one sticky cell per exception type; a hardware set outranks software
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= sw_val[i] | hw_set[i];
    end
  end

  assign summary = |flags;

  AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R4
  AST_SUMMARY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !summary); // R2
endmodule

// File: rtl/fpx_gate.sv
module fpx_gate #(
  parameter int MAX_INFLIGHT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req,
  input  logic issue_valid,
  input  logic done_valid,
  input  logic irq,
  output logic mode_q,
  output logic issue_ready
);
  localparam int CW = $clog2(MAX_INFLIGHT + 1);
  localparam logic [CW-1:0] CMAX = CW'(MAX_INFLIGHT);

  logic [CW-1:0] cnt;
  logic          fire, dec, idle, open_fast, open_ser;

  assign idle      = (cnt == '0);
  assign open_fast = (cnt < CMAX);
  assign open_ser  = idle && !irq;
  assign issue_ready = (mode_req == mode_q) && (mode_q ? open_ser : open_fast);
  assign fire = issue_valid && issue_ready;
  assign dec  = done_valid && !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt <= cnt + CW'(fire) - CW'(dec);
      if (idle) mode_q <= mode_req;
    end
  end

  AST_SER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (cnt <= CW'(1))); // R6
  AST_MODE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> ($past(cnt) == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX); // R10
endmodule

// File: rtl/fpx_trap.sv
module fpx_trap
  import fpx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial,
  input  logic              done_valid,
  input  exc_vec_t          done_exc,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic              ack,
  output logic              irq,
  output logic [ADDR_W-1:0] fault_addr
);
  logic hit;
  assign hit = serial && done_valid && (done_exc != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      fault_addr <= '0;
    end else if (hit) begin
      irq        <= 1'b1;
      fault_addr <= done_addr;
    end else if (ack) begin
      irq <= 1'b0;
    end
  end

  AST_FAST_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(serial)); // R5
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (irq && fault_addr == $past(done_addr))); // R7
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq); // R8
endmodule

// File: rtl/fpx_guard.sv
module fpx_guard
  import fpx_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int MAX_INFLIGHT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode_req,
  output logic              ser_mode,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic              done_valid,
  input  logic [4:0]        done_exc,
  input  logic [ADDR_W-1:0] done_addr,
  input  logic [1:0]        sw_op,
  input  logic [4:0]        sw_wdata,
  output logic [4:0]        sw_rdata,
  output logic              flag_summary,
  output logic              trap_irq,
  input  logic              trap_ack,
  output logic [ADDR_W-1:0] fault_addr
);
  exc_vec_t hw_set, flags;

  assign hw_set   = done_valid ? done_exc : '0;
  assign sw_rdata = flags;

  fpx_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (hw_set),
    .op      (sw_op_e'(sw_op)),
    .wdata   (sw_wdata),
    .flags   (flags),
    .summary (flag_summary)
  );

  fpx_gate #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_req    (ser_mode_req),
    .issue_valid (issue_valid),
    .done_valid  (done_valid),
    .irq         (trap_irq),
    .mode_q      (ser_mode),
    .issue_ready (issue_ready)
  );

  fpx_trap #(.ADDR_W(ADDR_W)) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .serial     (ser_mode),
    .done_valid (done_valid),
    .done_exc   (done_exc),
    .done_addr  (done_addr),
    .ack        (trap_ack),
    .irq        (trap_irq),
    .fault_addr (fault_addr)
  );

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_exc != '0) |=> flag_summary); // R1
endmodule

// File: tb/fpx_guard_bench.sv
module fpx_guard_bench;
  localparam int AW = 32;
  localparam int MAXF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_mode_req = 0, ser_mode, issue_valid = 0, issue_ready;
  logic done_valid = 0;
  logic [4:0] done_exc = '0;
  logic [AW-1:0] done_addr = '0;
  logic [1:0] sw_op = '0;
  logic [4:0] sw_wdata = '0, sw_rdata;
  logic flag_summary, trap_irq, trap_ack = 0;
  logic [AW-1:0] fault_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fpx_guard #(.ADDR_W(AW), .MAX_INFLIGHT(MAXF)) u_fpx_guard (
    .clk(clk), .rst_n(rst_n), .ser_mode_req(ser_mode_req), .ser_mode(ser_mode),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .done_valid(done_valid), .done_exc(done_exc), .done_addr(done_addr),
    .sw_op(sw_op), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .flag_summary(flag_summary), .trap_irq(trap_irq), .trap_ack(trap_ack),
    .fault_addr(fault_addr)
  );

  // {op, wdata, hw exc, old flags, new flags}
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 5'b00101, 5'b00000, 5'b00000, 5'b00101, 3'd3},
    {2'd0, 5'b11111, 5'b00000, 5'b00101, 5'b00101, 3'd3},
    {2'd1, 5'b10000, 5'b00010, 5'b00101, 5'b10111, 3'd1},
    {2'd2, 5'b00101, 5'b00000, 5'b10111, 5'b10010, 3'd3},
    {2'd3, 5'b01001, 5'b00000, 5'b10010, 5'b01001, 3'd3},
    {2'd2, 5'b11111, 5'b01000, 5'b01001, 5'b01000, 3'd4},
    {2'd3, 5'b00001, 5'b00100, 5'b01000, 5'b00101, 3'd4},
    {2'd2, 5'b11111, 5'b00000, 5'b00101, 5'b00000, 3'd2},
    {2'd0, 5'b00000, 5'b11111, 5'b00000, 5'b11111, 3'd1},
    {2'd3, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 3'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    #1;
    // reset state
    check("R2 reset summary", {31'd0, flag_summary}, 0);
    check("R1 reset flags", {27'd0, sw_rdata}, 0);
    check("R5 reset irq", {31'd0, trap_irq}, 0);
    check("R10 reset ready", {31'd0, issue_ready}, 1);

    // flag access table; an operation is issued first when hardware bits are used
    for (int k = 0; k < NV; k++) begin
      logic [1:0] op; logic [4:0] wd, hw, od, nw;
      {op, wd, hw, od, nw} = VEC[k][24:3];
      if (hw != 0) begin
        issue_valid = 1; step(); issue_valid = 0;
        done_valid = 1; done_exc = hw;
      end
      sw_op = op; sw_wdata = wd;
      #0.5;
      check("R3 old value returned", {27'd0, sw_rdata}, {27'd0, od});
      step();
      sw_op = 0; done_valid = 0; done_exc = 0;
      #0.5;
      if (hw != 0) check("R4 R1 flags after hw+sw", {27'd0, sw_rdata}, {27'd0, nw});
      else         check("R3 flags after access", {27'd0, sw_rdata}, {27'd0, nw});
      check("R2 summary", {31'd0, flag_summary}, {31'd0, nw != 0});
      check("R5 no irq in fast mode", {31'd0, trap_irq}, 0);
    end

    // fast mode: back-to-back issue up to the cap
    issue_valid = 1;
    for (int k = 0; k < MAXF; k++) begin
      check("R5 fast issue open", {31'd0, issue_ready}, 1);
      step();
    end
    check("R10 cap reached", {31'd0, issue_ready}, 0);
    issue_valid = 0;
    done_valid = 1; done_exc = 5'b00010; done_addr = 32'h40;
    step();
    done_exc = 0;
    check("R5 fast exception no irq", {31'd0, trap_irq}, 0);
    check("R1 divzero flag", {27'd0, sw_rdata}, 5'b00010);
    check("R10 reopens below cap", {31'd0, issue_ready}, 1);
    // one still in flight when serialize is requested
    done_valid = 1; step(); step(); done_valid = 0;
    ser_mode_req = 1;
    #0.5;
    check("R9 gate closed while change pending", {31'd0, issue_ready}, 0);
    step();
    check("R9 mode waits for drain", {31'd0, ser_mode}, 0);
    done_valid = 1; step(); done_valid = 0;
    check("R9 still pending at drain edge", {31'd0, ser_mode}, 0);
    step();
    check("R9 mode switched", {31'd0, ser_mode}, 1);
    check("R6 ready when idle", {31'd0, issue_ready}, 1);

    // serialize: clean operation
    issue_valid = 1; step(); issue_valid = 0;
    check("R6 one in flight blocks issue", {31'd0, issue_ready}, 0);
    done_valid = 1; done_addr = 32'h1000; step(); done_valid = 0;
    check("R7 clean completion no irq", {31'd0, trap_irq}, 0);
    check("R6 reopens after completion", {31'd0, issue_ready}, 1);
    // serialize: faulting operation
    issue_valid = 1; step(); issue_valid = 0;
    done_valid = 1; done_exc = 5'b00100; done_addr = 32'h1A4; step();
    done_valid = 0; done_exc = 0; done_addr = 0;
    check("R7 irq raised", {31'd0, trap_irq}, 1);
    check("R7 fault address", fault_addr, 32'h1A4);
    check("R6 gate closed while irq", {31'd0, issue_ready}, 0);
    issue_valid = 1;
    step(); step(); step();
    check("R8 irq held", {31'd0, trap_irq}, 1);
    check("R6 nothing issued during irq", {31'd0, issue_ready}, 0);
    issue_valid = 0;
    trap_ack = 1; step(); trap_ack = 0;
    check("R8 irq cleared by ack", {31'd0, trap_irq}, 0);
    check("R6 gate reopens after ack", {31'd0, issue_ready}, 1);
    check("R1 overflow flag kept", {27'd0, sw_rdata}, 5'b00110);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule